// File: doc/BRIEF.md
# Window Watchdog Supervisor with Timing Register

This block supervises system software. The software has to send a clear strobe at regular intervals, and the block requests a reset when that service is missed or comes too early. Software programs the block through a 4-bit register port at a single address. Bit 3 of the write data chooses the target. With bit 3 low, the write goes to the timing configuration: a window-mode flag and a two-bit period selector. With bit 3 high, the write goes to a three-bit cyclic-sense period code, which the block drives out unchanged to an external switch sequencer.

A read strobe never returns the stored configuration. It captures four fault flags supplied by external detectors, no matter which target was written last. A quarter-millisecond tick enable is the time base. The four periods map to 39, 180, 400 and 1400 ticks. In window mode, the first half of each period is closed, and a clear strobe that arrives in the closed half counts as a fault. In timeout mode, a clear strobe is accepted at any time. Every fault produces a one-cycle reset request and starts a new period.

Top module: `wdt_window_supervisor`

## Requirements
- R1: After reset, the window flag, the period selector and the cyclic-sense code are 0, `cyc_code` and `rd_data` read 0, `rst_req` is low, and the watchdog runs in 39-tick timeout mode.
- R2: Period selector values 0, 1, 2 and 3 give terminal counts of 39, 180, 400 and 1400 ticks. If no clear strobe arrives, `rst_req` goes high in the cycle after the terminal-count tick, counted from the last restart.
- R3: The period count advances only in cycles where `tick_en` is high. Idle cycles neither advance it nor raise `rst_req`.
- R4: In timeout mode (window flag 0), a clear strobe at any count restarts the period at zero and does not raise `rst_req`.
- R5: In window mode (window flag 1), a clear strobe while the count is below half of the terminal count (truncated: 19, 90, 200, 700) raises `rst_req` in the next cycle and restarts the period.
- R6: In window mode, a clear strobe at or above the half count restarts the period without raising `rst_req`. The next expiry then comes a full terminal count of ticks later.
- R7: A write with `wr_data[3]`=0 loads the window flag from `wr_data[2]` and the period selector from `wr_data[1:0]`, and restarts the period at zero.
- R8: A write with `wr_data[3]`=1 loads the cyclic-sense code from `wr_data[2:0]`, and that code appears on `cyc_code` in the next cycle. The timing configuration and the running count are left unchanged.
- R9: When `rd_en` is high, `fault_in[3:0]` is captured. It shows on `rd_data[3:0]` in the next cycle, with bit 3 = bus-low shorted to logic supply, bit 2 = shorted to battery, bit 1 = shorted to ground, and bit 0 = transmit input stuck dominant. `rd_data` holds its value while `rd_en` is low.
- R10: Each expiry or closed-window fault gives a `rst_req` pulse exactly one cycle long, and the period then restarts from zero.
- R11: If a timing write and a clear strobe arrive in the same cycle, the write takes priority. The clear strobe is ignored, so it cannot cause a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Quarter-millisecond time-base enable |
| kick | input | 1 | Watchdog clear strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data: bit 3 selects the target |
| rd_en | input | 1 | Register read strobe |
| fault_in | input | 4 | Fault flags from external detectors |
| rd_data | output | 4 | Captured fault flags |
| cyc_code | output | 3 | Stored cyclic-sense period code |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Internal state is visible only through when `rst_req` fires. A wrong count, a wrong half-point or a restart that never happened moves the reset pulse or makes it disappear. That shift shows up at the next expiry, at most one terminal count of ticks later, or at once on a clear strobe placed next to the window edge. For this reason the clear-strobe position is swept over every count of the shortest period, in both modes. The write path is observed directly on `cyc_code`, and its effect on the count is observed through when the next expiry arrives.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    MODE_TIMEOUT = 1'b0,
    MODE_WINDOW  = 1'b1
  } wdt_mode_e;

  typedef struct packed {
    wdt_mode_e  mode;
    logic [1:0] per_sel;
  } wdt_cfg_t;

  localparam int unsigned SEL_BIT = 3;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW     = 4,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [DW-1:0]     fault_in,
  output wdt_cfg_t          cfg,
  output logic              tim_wr,
  output logic [CODE_W-1:0] code,
  output logic [DW-1:0]     rd_data
);

  wdt_cfg_t          cfg_q, cfg_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [DW-1:0]     rd_q, rd_d;
  logic              csp_wr;

  assign tim_wr = wr_en & ~wr_data[SEL_BIT];
  assign csp_wr = wr_en &  wr_data[SEL_BIT];

  always_comb begin
    cfg_d  = cfg_q;
    code_d = code_q;
    rd_d   = rd_q;
    if (tim_wr) begin
      cfg_d.mode    = wdt_mode_e'(wr_data[2]);
      cfg_d.per_sel = wr_data[1:0];
    end
    if (csp_wr) code_d = wr_data[CODE_W-1:0];
    if (rd_en)  rd_d   = fault_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{mode: MODE_TIMEOUT, per_sel: 2'b00};
      code_q <= '0;
      rd_q   <= '0;
    end else begin
      cfg_q  <= cfg_d;
      code_q <= code_d;
      rd_q   <= rd_d;
    end
  end

  assign cfg     = cfg_q;
  assign code    = code_q;
  assign rd_data = rd_q;

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[SEL_BIT]) |=> $stable(code_q)); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_data[SEL_BIT]) |=> $stable(cfg_q)); // R7
  AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[SEL_BIT]) |=> code_q == $past(wr_data[CODE_W-1:0])); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q)); // R9

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int TC0   = 39,
  parameter int TC1   = 180,
  parameter int TC2   = 400,
  parameter int TC3   = 1400,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [1:0]       per_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] half,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term;

  always_comb begin
    case (per_sel)
      2'd0:    term = CNT_W'(TC0);
      2'd1:    term = CNT_W'(TC1);
      2'd2:    term = CNT_W'(TC2);
      default: term = CNT_W'(TC3);
    endcase
  end

  assign half = term >> 1;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (cnt_q == term - CNT_W'(1)) begin
        expire = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_BELOW_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < term); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(cnt_q)); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0); // R7

endmodule

// File: rtl/wdt_judge.sv
module wdt_judge
  import wdt_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             tim_wr,
  input  wdt_mode_e        mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] half,
  input  logic             expire,
  output logic             restart,
  output logic             rst_req
);

  logic kick_eff, win_open, early, fail_d, req_q;

  assign kick_eff = kick & ~tim_wr;
  assign win_open = (mode == MODE_TIMEOUT) || (cnt >= half);
  assign early    = kick_eff & ~win_open;
  assign restart  = tim_wr | kick_eff;
  assign fail_d   = expire | early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fail_d;
  end

  assign rst_req = req_q;

  AST_EARLY_KICK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !tim_wr && mode == MODE_WINDOW && cnt < half) |=> rst_req); // R5
  AST_LEGAL_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !tim_wr && (mode == MODE_TIMEOUT || cnt >= half)) |=> !rst_req); // R6
  AST_WRITE_BEATS_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    tim_wr |=> !rst_req); // R11

endmodule

// File: rtl/wdt_window_supervisor.sv
module wdt_window_supervisor
  import wdt_pkg::*;
#(
  parameter int DW     = 4,
  parameter int CODE_W = 3,
  parameter int TC0    = 39,
  parameter int TC1    = 180,
  parameter int TC2    = 400,
  parameter int TC3    = 1400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              kick,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [DW-1:0]     fault_in,
  output logic [DW-1:0]     rd_data,
  output logic [CODE_W-1:0] cyc_code,
  output logic              rst_req
);

  localparam int TC_A   = (TC0 > TC1) ? TC0 : TC1;
  localparam int TC_B   = (TC2 > TC3) ? TC2 : TC3;
  localparam int TC_MAX = (TC_A > TC_B) ? TC_A : TC_B;
  localparam int CNT_W  = $clog2(TC_MAX + 1);

  logic             rst_n_s;
  wdt_cfg_t         cfg;
  logic             tim_wr;
  logic             restart;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  wdt_regs #(.DW(DW), .CODE_W(CODE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .fault_in (fault_in),
    .cfg      (cfg),
    .tim_wr   (tim_wr),
    .code     (cyc_code),
    .rd_data  (rd_data)
  );

  wdt_timebase #(
    .TC0(TC0), .TC1(TC1), .TC2(TC2), .TC3(TC3), .CNT_W(CNT_W)
  ) u_tb (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_en (tick_en),
    .restart (restart),
    .per_sel (cfg.per_sel),
    .cnt     (cnt),
    .half    (half),
    .expire  (expire)
  );

  wdt_judge #(.CNT_W(CNT_W)) u_judge (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .kick    (kick),
    .tim_wr  (tim_wr),
    .mode    (cfg.mode),
    .cnt     (cnt),
    .half    (half),
    .expire  (expire),
    .restart (restart),
    .rst_req (rst_req)
  );

  AST_EXPIRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (expire && !kick && !tim_wr) |=> (rst_req && cnt == '0)); // R10

endmodule

// File: tb/wdt_window_supervisor_test.sv
`timescale 1ns/1ps
module wdt_window_supervisor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       rd_en = 1'b0;
  logic [3:0] fault_in = 4'h0;
  logic [3:0] rd_data;
  logic [2:0] cyc_code;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_window_supervisor uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .fault_in(fault_in),
    .rd_data(rd_data), .cyc_code(cyc_code), .rst_req(rst_req)
  );

  function automatic int term_of(int sel);
    case (sel)
      0: return 39;
      1: return 180;
      2: return 400;
      default: return 1400;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write(logic [3:0] d, logic with_kick = 1'b0);
    wr_en = 1'b1; wr_data = d; kick = with_kick;
    step();
    wr_en = 1'b0; kick = 1'b0;
  endtask

  task automatic tick_quiet(int n, string tag);
    int pulses = 0;
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      step();
      if (rst_req) pulses++;
    end
    tick_en = 1'b0;
    check(tag, pulses, 0);
  endtask

  task automatic tick_fire(string tag);
    tick_en = 1'b1;
    step();
    tick_en = 1'b0;
    check(tag, int'(rst_req), 1);
    step();
    check({tag, " single"}, int'(rst_req), 0);
  endtask

  task automatic do_kick(string tag, int exp);
    kick = 1'b1;
    step();
    kick = 1'b0;
    check(tag, int'(rst_req), exp);
    step();
    check({tag, " end"}, int'(rst_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state and default 39-tick timeout
    check("R1 rst_req", int'(rst_req), 0);
    check("R1 cyc_code", int'(cyc_code), 0);
    check("R1 rd_data", int'(rd_data), 0);
    kick = 1'b1; step(); kick = 1'b0;
    check("R1 early kick in timeout default", int'(rst_req), 0);
    tick_quiet(38, "R1 quiet");
    tick_fire("R1 expiry");

    // R2 R10: every period in both modes, expiry then restart
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        write(4'((m << 2) | s));
        tick_quiet(term_of(s) - 1, "R2 quiet");
        tick_fire("R2 expiry");
        tick_quiet(term_of(s) - 1, "R10 quiet after restart");
        tick_fire("R10 second expiry");
      end
    end

    // R3 idle cycles do not advance the count
    write(4'b0000);
    tick_quiet(20, "R3 pre");
    repeat (200) begin
      step();
      if (rst_req) check("R3 idle pulse", 1, 0);
    end
    tick_quiet(18, "R3 post");
    tick_fire("R3 expiry");

    // R4 R5: exhaustive kick position sweep on the 39-tick period
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 39; n++) begin
        write(4'((m << 2)));
        if (n > 0) tick_quiet(n, "R4 R5 position");
        do_kick(m ? "R5 window kick" : "R4 timeout kick", (m == 1 && n < 19) ? 1 : 0);
      end
    end

    // R5 R6: boundaries on the longer periods, and restart after a legal kick
    for (int s = 1; s < 4; s++) begin
      write(4'(4 | s));
      tick_quiet(term_of(s) / 2 - 1, "R5 approach");
      do_kick("R5 last closed count", 1);
      tick_quiet(term_of(s) / 2, "R6 approach");
      do_kick("R6 first open count", 0);
      tick_quiet(term_of(s) - 1, "R6 restart quiet");
      tick_fire("R6 full period after kick");
    end

    // R4 kick at terminal minus one in timeout mode restarts
    write(4'b0011);
    tick_quiet(1399, "R4 late");
    do_kick("R4 kick at last count", 0);
    tick_quiet(1399, "R4 restart quiet");
    tick_fire("R4 expiry");

    // R7 timing write restarts mid-period
    write(4'b0000);
    tick_quiet(30, "R7 pre");
    write(4'b0000);
    tick_quiet(38, "R7 restarted");
    tick_fire("R7 expiry");

    // R8 cyclic code writes keep timing and count
    write(4'b0000);
    tick_quiet(10, "R8 pre");
    for (int c = 0; c < 8; c++) begin
      write(4'(8 | c));
      check("R8 cyc_code", int'(cyc_code), c);
    end
    tick_quiet(28, "R8 count kept");
    tick_fire("R8 expiry");
    write(4'b0100);
    tick_quiet(10, "R8 win pre");
    write(4'b1101);
    check("R8 cyc_code 5", int'(cyc_code), 5);
    do_kick("R8 window mode kept", 1);
    write(4'b0000);
    check("R8 timing write leaves code", int'(cyc_code), 5);

    // R11 write beats a simultaneous kick
    write(4'b0100);
    tick_quiet(5, "R11 pre");
    write(4'b0100, 1'b1);
    check("R11 no fault", int'(rst_req), 0);
    tick_quiet(38, "R11 restarted");
    tick_fire("R11 expiry");

    // R9 read capture for every fault pattern
    for (int d = 0; d < 16; d++) begin
      fault_in = 4'(d);
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
      check("R9 capture", int'(rd_data), d);
      fault_in = ~4'(d);
      write(4'(d));
      check("R9 hold", int'(rd_data), d);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule